// File: doc/BRIEF.md
# Sector Hamming ECC Engine

This block computes and checks a single-error-correcting parity code over one flash sector, 512 bytes by default. Sector bytes arrive one per handshake on a valid/ready byte port after a start-of-sector pulse. The bit address of each data bit is its byte index times eight plus its bit number, 12 bits for a 512-byte sector. The block keeps two 12-bit parity halves. The odd half has one parity bit per address bit over the data bits whose address has that bit set. The even half covers the data bits whose address has that bit clear.

In generate mode the block sends the 3-byte code that goes into the spare area. In check mode it also takes the 3 stored code bytes, on their own handshake port and in either order relative to the data. It then reports a single result: clean, correctable data error (with byte index and flip mask), error confined to the stored code, or uncorrectable. The code is stored inverted, so an erased sector and its erased code check as clean. Applying the flip to a buffer is left to the consumer.

Top module: `sec_ecc_engine`

## Requirements
- R1: The code word is the bitwise inverse of {odd half, even half}. For a sector of SECTOR_BYTES = 512 that is 24 bits, with the odd half in bits [23:12]. Parity bit k of the odd half is the XOR of all data bits whose bit address (byte_index*8 + bit) has bit k set. Parity bit k of the even half covers the data bits whose address has bit k clear.
- R2: In generate mode (mode_check_i = 0 at the start pulse) the code appears on code_out_data_o least significant byte first. It takes three consecutive cycles with code_out_valid_o high, starting at the clock edge that accepts the last data byte. No result pulse is produced in this mode.
- R3: A sector of all 0xFF bytes generates the code bytes FF FF FF, and it checks clean against a stored code of FF FF FF.
- R4: A sos_i pulse clears the parity and code state and opens a new sector, so a sector's result does not depend on any earlier sector. mode_check_i is sampled with sos_i: 1 selects check mode, 0 selects generate mode.
- R5: byte_ready_o is high from the edge after sos_i until SECTOR_BYTES bytes have been accepted, then low. code_ready_o is high in check mode until 3 code bytes have been accepted, and it is always low in generate mode.
- R6: In check mode res_valid_o is high for exactly one cycle. It starts at the first edge after the edge that accepts the later of the last data byte and the last code byte, whichever port finishes last.
- R7: Status encoding on res_status_o: 0 clean, 1 data bit corrected, 2 error only in the stored code, 3 uncorrectable. Let diff be the recomputed code XOR the stored code. A diff of zero gives status 0.
- R8: If the upper 12 bits of diff XOR the lower 12 bits equal 0xFFF and diff[23:15] < SECTOR_BYTES, the status is 1. res_byte_o is then diff[23:15] and res_mask_o is 1 << diff[14:12].
- R9: If the halves of diff form such a complementary pair but the byte index is not below SECTOR_BYTES, the status is 3.
- R10: If diff has exactly one bit set, the status is 2, and res_byte_o and res_mask_o are zero.
- R11: Any other nonzero diff, including two flipped data bits, gives status 3. Whenever the status is not 1, res_byte_o and res_mask_o are zero.
- R12: After reset, byte_ready_o, code_ready_o, code_out_valid_o and res_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sos_i | input | 1 | Start-of-sector pulse; clears state |
| mode_check_i | input | 1 | Sampled with sos_i: 1 check, 0 generate |
| byte_valid_i | input | 1 | Data byte valid |
| byte_data_i | input | 8 | Sector data byte |
| byte_ready_o | output | 1 | Data byte accepted when high with valid |
| code_valid_i | input | 1 | Stored code byte valid |
| code_data_i | input | 8 | Stored code byte, LSB byte first |
| code_ready_o | output | 1 | Stored code byte accepted when high with valid |
| code_out_valid_o | output | 1 | Generated code byte valid |
| code_out_data_o | output | 8 | Generated code byte, LSB byte first |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_status_o | output | 2 | Result status per R7 |
| res_byte_o | output | IDX_W (9) | Byte index to correct |
| res_mask_o | output | 8 | Bit mask to XOR into that byte |

## Verification
A wrong parity bit is invisible until the sector ends. It then shows either as a mismatched generated code byte or as a wrong status. In the status case it is typically a single data bit error reported as error-free or at the wrong byte, so every one of the 48 data-bit positions of a small sector and sampled positions of a full sector are flipped. A stale accumulator, or a counter that runs past the sector, shows in the first sector after another one as a nonclean result on good data. A mistimed done flag shows as a result strobe one cycle early or late, or twice. The bench measures that strobe against the final handshake with the code bytes both before and after the data.

// File: rtl/sec_ecc_pkg.sv
package sec_ecc_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'd0,
    ST_FIXED = 2'd1,
    ST_CODE  = 2'd2,
    ST_FATAL = 2'd3
  } ecc_status_e;

  // bits of a byte whose bit-number has bit k set
  function automatic logic [7:0] col_sel(input int k);
    logic [7:0] m;
    for (int b = 0; b < 8; b++) m[b] = ((b >> k) & 1) == 1;
    return m;
  endfunction

endpackage

// File: rtl/sec_ecc_parity_acc.sv
module sec_ecc_parity_acc #(
  parameter  int IDX_W  = 9,
  localparam int HALF_W = IDX_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [7:0]        data_i,
  output logic [HALF_W-1:0] odd_o,
  output logic [HALF_W-1:0] even_o
);
  import sec_ecc_pkg::*;

  logic [HALF_W-1:0] odd_q, even_q, odd_upd, even_upd;
  logic              row_par;

  assign row_par = ^data_i;

  for (genvar k = 0; k < HALF_W; k++) begin : g_bit
    if (k < 3) begin : g_col
      localparam logic [7:0] SEL = col_sel(k);
      assign odd_upd[k]  = ^(data_i & SEL);
      assign even_upd[k] = ^(data_i & ~SEL);
    end else begin : g_row
      assign odd_upd[k]  = idx_i[k-3] & row_par;
      assign even_upd[k] = ~idx_i[k-3] & row_par;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      odd_q  <= '0;
      even_q <= '0;
    end else if (clr_i) begin
      odd_q  <= '0;
      even_q <= '0;
    end else if (en_i) begin
      odd_q  <= odd_q ^ odd_upd;
      even_q <= even_q ^ even_upd;
    end
  end

  assign odd_o  = odd_q;
  assign even_o = even_q;

endmodule

// File: rtl/sec_ecc_code_cap.sv
module sec_ecc_code_cap #(
  parameter  int NB   = 3,
  localparam int CW   = $clog2(NB + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            en_i,
  input  logic [7:0]      data_i,
  output logic [NB*8-1:0] code_o,
  output logic            done_o
);
  logic [CW-1:0]   cnt_q;
  logic [NB*8-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      code_q <= '0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      code_q <= '0;
    end else if (en_i) begin
      cnt_q <= cnt_q + 1'b1;
      for (int i = 0; i < NB; i++)
        if (cnt_q == CW'(i)) code_q[i*8 +: 8] <= data_i;
    end
  end

  assign code_o = code_q;
  assign done_o = (cnt_q == CW'(NB));

endmodule

// File: rtl/sec_ecc_code_ser.sv
module sec_ecc_code_ser #(
  parameter  int NB = 3,
  localparam int CW = $clog2(NB + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            start_i,
  input  logic [NB*8-1:0] code_i,
  output logic            valid_o,
  output logic [7:0]      data_o
);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             left_q <= '0;
    else if (clr_i)          left_q <= '0;
    else if (start_i)        left_q <= CW'(NB);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  // code_i is read live: the accumulator is final from the start edge on
  always_comb begin
    data_o = '0;
    for (int i = 0; i < NB; i++)
      if (left_q == CW'(NB - i)) data_o = code_i[i*8 +: 8];
  end

  assign valid_o = (left_q != '0);

endmodule

// File: rtl/sec_ecc_classify.sv
module sec_ecc_classify #(
  parameter  int SECTOR_BYTES = 512,
  parameter  int IDX_W        = 9,
  localparam int HALF_W       = IDX_W + 3,
  localparam int CODE_W       = 2 * HALF_W
) (
  input  logic [CODE_W-1:0]        calc_i,
  input  logic [CODE_W-1:0]        stored_i,
  output sec_ecc_pkg::ecc_status_e status_o,
  output logic [IDX_W-1:0]         byte_o,
  output logic [7:0]               mask_o
);
  import sec_ecc_pkg::*;

  logic [CODE_W-1:0] diff;
  logic [HALF_W-1:0] hi, lo;
  logic [IDX_W-1:0]  idx;
  logic [2:0]        bitpos;
  logic              pair, one_bit, in_range;

  assign diff    = calc_i ^ stored_i;
  assign hi      = diff[CODE_W-1:HALF_W];
  assign lo      = diff[HALF_W-1:0];
  assign idx     = hi[HALF_W-1:3];
  assign bitpos  = hi[2:0];
  assign pair    = ((hi ^ lo) == '1);
  assign one_bit = (diff != '0) && ((diff & (diff - 1'b1)) == '0);

  if ((1 << IDX_W) == SECTOR_BYTES) begin : g_pow2
    assign in_range = 1'b1;
  end else begin : g_limit
    localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(SECTOR_BYTES);
    assign in_range = ({1'b0, idx} < LIMIT);
  end

  always_comb begin
    status_o = ST_FATAL;
    byte_o   = '0;
    mask_o   = '0;
    if (diff == '0) begin
      status_o = ST_CLEAN;
    end else if (pair) begin
      if (in_range) begin
        status_o = ST_FIXED;
        byte_o   = idx;
        mask_o   = 8'h01 << bitpos;
      end
    end else if (one_bit) begin
      status_o = ST_CODE;
    end
  end

endmodule

// File: rtl/sec_ecc_engine.sv
module sec_ecc_engine #(
  parameter  int SECTOR_BYTES = 512,
  localparam int IDX_W        = $clog2(SECTOR_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sos_i,
  input  logic             mode_check_i,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_data_i,
  output logic             byte_ready_o,
  input  logic             code_valid_i,
  input  logic [7:0]       code_data_i,
  output logic             code_ready_o,
  output logic             code_out_valid_o,
  output logic [7:0]       code_out_data_o,
  output logic             res_valid_o,
  output logic [1:0]       res_status_o,
  output logic [IDX_W-1:0] res_byte_o,
  output logic [7:0]       res_mask_o
);
  import sec_ecc_pkg::*;

  localparam int HALF_W   = IDX_W + 3;
  localparam int CODE_W   = 2 * HALF_W;
  localparam int CODE_NB  = (CODE_W + 7) / 8;
  localparam int CODE_PAD = CODE_NB * 8 - CODE_W;
  localparam int CNT_W    = $clog2(SECTOR_BYTES + 1);

  logic                 active_q, mode_q, res_sent_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 data_done, byte_hs, code_hs, last_byte, cap_done, fire;
  logic [HALF_W-1:0]    acc_odd, acc_even;
  logic [CODE_W-1:0]    code_calc;
  logic [CODE_NB*8-1:0] code_word, stored_word;
  ecc_status_e          cls_status;
  logic [IDX_W-1:0]     cls_byte;
  logic [7:0]           cls_mask;
  logic                 res_valid_q;
  logic [1:0]           res_status_q;
  logic [IDX_W-1:0]     res_byte_q;
  logic [7:0]           res_mask_q;

  assign data_done    = (cnt_q == CNT_W'(SECTOR_BYTES));
  assign byte_ready_o = active_q & ~data_done;
  assign code_ready_o = active_q & mode_q & ~cap_done;
  assign byte_hs      = byte_valid_i & byte_ready_o & ~sos_i;
  assign code_hs      = code_valid_i & code_ready_o & ~sos_i;
  assign last_byte    = byte_hs && (cnt_q == CNT_W'(SECTOR_BYTES - 1));
  assign fire         = active_q & mode_q & data_done & cap_done & ~res_sent_q & ~sos_i;

  sec_ecc_parity_acc #(.IDX_W(IDX_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sos_i),
    .en_i   (byte_hs),
    .idx_i  (cnt_q[IDX_W-1:0]),
    .data_i (byte_data_i),
    .odd_o  (acc_odd),
    .even_o (acc_even)
  );

  // inverted so that an erased sector yields an erased code
  assign code_calc = ~{acc_odd, acc_even};

  if (CODE_PAD > 0) begin : g_pad
    assign code_word = {{CODE_PAD{1'b1}}, code_calc};
  end else begin : g_nopad
    assign code_word = code_calc;
  end

  sec_ecc_code_ser #(.NB(CODE_NB)) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (sos_i),
    .start_i (last_byte & ~mode_q),
    .code_i  (code_word),
    .valid_o (code_out_valid_o),
    .data_o  (code_out_data_o)
  );

  sec_ecc_code_cap #(.NB(CODE_NB)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sos_i),
    .en_i   (code_hs),
    .data_i (code_data_i),
    .code_o (stored_word),
    .done_o (cap_done)
  );

  sec_ecc_classify #(.SECTOR_BYTES(SECTOR_BYTES), .IDX_W(IDX_W)) u_cls (
    .calc_i   (code_calc),
    .stored_i (stored_word[CODE_W-1:0]),
    .status_o (cls_status),
    .byte_o   (cls_byte),
    .mask_o   (cls_mask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      mode_q     <= 1'b0;
      cnt_q      <= '0;
      res_sent_q <= 1'b0;
    end else if (sos_i) begin
      active_q   <= 1'b1;
      mode_q     <= mode_check_i;
      cnt_q      <= '0;
      res_sent_q <= 1'b0;
    end else begin
      if (byte_hs) cnt_q <= cnt_q + 1'b1;
      if (fire)    res_sent_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_q  <= 1'b0;
      res_status_q <= '0;
      res_byte_q   <= '0;
      res_mask_q   <= '0;
    end else begin
      res_valid_q <= fire;
      if (fire) begin
        res_status_q <= cls_status;
        res_byte_q   <= cls_byte;
        res_mask_q   <= cls_mask;
      end
    end
  end

  assign res_valid_o  = res_valid_q;
  assign res_status_o = res_status_q;
  assign res_byte_o   = res_byte_q;
  assign res_mask_o   = res_mask_q;

endmodule

// File: rtl/sec_ecc_engine_chk.sv
module sec_ecc_engine_chk #(
  parameter  int SECTOR_BYTES = 512,
  localparam int IDX_W        = $clog2(SECTOR_BYTES),
  localparam int HALF_W       = IDX_W + 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sos_i,
  input logic              byte_ready_o,
  input logic              code_ready_o,
  input logic              code_out_valid_o,
  input logic              res_valid_o,
  input logic [1:0]        res_status_o,
  input logic [IDX_W-1:0]  res_byte_o,
  input logic [7:0]        res_mask_o,
  input logic              mode_q,
  input logic [HALF_W-1:0] acc_odd,
  input logic [HALF_W-1:0] acc_even
);

  p_clear_on_sos_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sos_i |=> (acc_odd == '0 && acc_even == '0));

  p_res_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);

  p_res_check_mode_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> mode_q);

  p_code_out_gen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_out_valid_o |-> (!mode_q && !byte_ready_o));

  p_code_burst_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(code_out_valid_o) |=> code_out_valid_o);

  p_code_ready_gen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q |-> !code_ready_o);

  p_fixed_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_status_o == 2'd1) |->
      ($onehot(res_mask_o) && (int'(res_byte_o) < SECTOR_BYTES)));

  p_other_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_status_o != 2'd1) |-> (res_mask_o == '0 && res_byte_o == '0));

endmodule

bind sec_ecc_engine sec_ecc_engine_chk #(.SECTOR_BYTES(SECTOR_BYTES)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .sos_i            (sos_i),
  .byte_ready_o     (byte_ready_o),
  .code_ready_o     (code_ready_o),
  .code_out_valid_o (code_out_valid_o),
  .res_valid_o      (res_valid_o),
  .res_status_o     (res_status_o),
  .res_byte_o       (res_byte_o),
  .res_mask_o       (res_mask_o),
  .mode_q           (mode_q),
  .acc_odd          (acc_odd),
  .acc_even         (acc_even)
);

// File: tb/sec_ecc_engine_bench.sv
`timescale 1ns/1ps
module sec_ecc_engine_bench;

  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sos = 1'b0, mode = 1'b0, bv = 1'b0, cv = 1'b0, sel = 1'b0;
  logic [7:0] bd = '0, cd = '0;

  always #2.5 clk = ~clk;

  // main instance (512-byte sector) and a small one (6-byte sector)
  logic       a_br, a_cr, a_cov, a_rv, b_br, b_cr, b_cov, b_rv;
  logic [7:0] a_cod, a_msk, b_cod, b_msk;
  logic [1:0] a_st, b_st;
  logic [8:0] a_byt;
  logic [2:0] b_byt;

  sec_ecc_engine u_sec_ecc_engine (
    .clk_i(clk), .rst_ni(rst_n), .sos_i(sos & ~sel), .mode_check_i(mode),
    .byte_valid_i(bv & ~sel), .byte_data_i(bd), .byte_ready_o(a_br),
    .code_valid_i(cv & ~sel), .code_data_i(cd), .code_ready_o(a_cr),
    .code_out_valid_o(a_cov), .code_out_data_o(a_cod),
    .res_valid_o(a_rv), .res_status_o(a_st), .res_byte_o(a_byt), .res_mask_o(a_msk)
  );

  sec_ecc_engine #(.SECTOR_BYTES(6)) u_sec_ecc_engine_small (
    .clk_i(clk), .rst_ni(rst_n), .sos_i(sos & sel), .mode_check_i(mode),
    .byte_valid_i(bv & sel), .byte_data_i(bd), .byte_ready_o(b_br),
    .code_valid_i(cv & sel), .code_data_i(cd), .code_ready_o(b_cr),
    .code_out_valid_o(b_cov), .code_out_data_o(b_cod),
    .res_valid_o(b_rv), .res_status_o(b_st), .res_byte_o(b_byt), .res_mask_o(b_msk)
  );

  logic       rdy, crdy, cov, rv;
  logic [7:0] cod, msk;
  logic [1:0] st;
  logic [8:0] byt;
  assign rdy  = sel ? b_br  : a_br;
  assign crdy = sel ? b_cr  : a_cr;
  assign cov  = sel ? b_cov : a_cov;
  assign cod  = sel ? b_cod : a_cod;
  assign rv   = sel ? b_rv  : a_rv;
  assign st   = sel ? b_st  : a_st;
  assign byt  = sel ? {6'd0, b_byt} : a_byt;
  assign msk  = sel ? b_msk : a_msk;

  int checks = 0, fails = 0;
  int cyc = 0, last_hs = 0, first_cov = 0, cap_n = 0, res_n = 0, res_cyc = 0;
  logic [31:0] cap_code = '0;
  logic [1:0]  r_st = '0;
  logic [8:0]  r_byt = '0;
  logic [7:0]  r_msk = '0;
  logic [7:0]  mem [512];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if ((bv && rdy) || (cv && crdy)) last_hs <= cyc + 1;
  end

  always @(negedge clk) begin
    if (cov) begin
      if (cap_n == 0) first_cov = cyc;
      if (cap_n < 4) cap_code[cap_n*8 +: 8] = cod;
      cap_n++;
    end
    if (rv) begin
      res_n++;
      res_cyc = cyc;
      r_st = st; r_byt = byt; r_msk = msk;
    end
  end

  task automatic summary_and_end();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cyc == WATCHDOG) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary_and_end();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bench model: XOR of bit addresses of the set bits
  function automatic logic [31:0] model_code(input int n, input int hw);
    logic [31:0] odd = 0, even = 0, hm, full, cm, pad;
    int cb;
    hm = (32'd1 << hw) - 1;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++)
        if (mem[i][b]) begin
          odd  ^= 32'(i*8 + b);
          even ^= ~32'(i*8 + b) & hm;
        end
    cm   = (32'd1 << (2*hw)) - 1;
    full = ~((odd << hw) | even) & cm;
    cb   = (2*hw + 7) / 8;
    pad  = ((32'd1 << (cb*8)) - 1) & ~cm;
    return full | pad;
  endfunction

  task automatic fill_rand(input int n);
    for (int i = 0; i < n; i++) mem[i] = 8'($urandom);
  endtask

  task automatic send(input bit is_code, input logic [7:0] v);
    if (is_code) begin
      cv = 1'b1; cd = v;
      while (!crdy) @(negedge clk);
      @(negedge clk); cv = 1'b0;
    end else begin
      bv = 1'b1; bd = v;
      while (!rdy) @(negedge clk);
      @(negedge clk); bv = 1'b0;
    end
  endtask

  task automatic run_sector(input bit chkm, input int n, input int cb,
                            input logic [31:0] stored, input bit code_first);
    @(negedge clk);
    sos = 1'b1; mode = chkm;
    @(negedge clk);
    sos = 1'b0; cap_n = 0; res_n = 0; cap_code = '0;
    if (chkm && code_first)
      for (int j = 0; j < cb; j++) send(1'b1, stored[j*8 +: 8]);
    for (int i = 0; i < n; i++) send(1'b0, mem[i]);
    if (chkm && !code_first)
      for (int j = 0; j < cb; j++) send(1'b1, stored[j*8 +: 8]);
    repeat (5) @(negedge clk);
  endtask

  task automatic expect_res(input string req, input logic [1:0] e_st,
                            input logic [8:0] e_byt, input logic [7:0] e_msk);
    chk(res_n == 1, "R6", "result strobe count", res_n, 1);
    chk(res_cyc - last_hs == 1, "R6", "result latency", res_cyc - last_hs, 1);
    chk(r_st == e_st, req, "status", r_st, e_st);
    chk(r_byt == e_byt && r_msk == e_msk, req, "byte/mask",
        {r_byt, r_msk}, {e_byt, e_msk});
  endtask

  task automatic gen_and_compare(input string req, input int n, input int cb, input int hw);
    logic [31:0] exp_code, cm;
    run_sector(1'b0, n, cb, 32'd0, 1'b0);
    cm = (32'd1 << (cb*8)) - 1;
    exp_code = model_code(n, hw);
    chk(cap_n == cb, "R2", "code byte count", cap_n, cb);
    chk(first_cov == last_hs, "R2", "code start cycle", first_cov, last_hs);
    chk((cap_code & cm) == exp_code, req, "generated code", cap_code & cm, exp_code);
    chk(res_n == 0, "R2", "no result in generate mode", res_n, 0);
    chk(!rdy && !crdy, "R5", "ready after sector", {rdy, crdy}, 0);
  endtask

  // flip data bit a, present the original code: expect a correction
  task automatic data_flip(input int n, input int cb, input int hw, input int a);
    logic [31:0] good;
    good = model_code(n, hw);
    mem[a/8][a%8] = ~mem[a/8][a%8];
    run_sector(1'b1, n, cb, good, a[0]);
    expect_res("R8", 2'd1, 9'(a/8), 8'd1 << (a%8));
    mem[a/8][a%8] = ~mem[a/8][a%8];
  endtask

  initial begin
    logic [31:0] good, hi, lo, d;
    int a1, a2;
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(!a_br && !a_cr && !a_cov && !a_rv, "R12", "main outputs in reset",
        {a_br, a_cr, a_cov, a_rv}, 0);
    chk(!b_br && !b_cr && !b_cov && !b_rv, "R12", "small outputs in reset",
        {b_br, b_cr, b_cov, b_rv}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!a_br && !a_cr && !a_cov && !a_rv, "R12", "idle after reset",
        {a_br, a_cr, a_cov, a_rv}, 0);

    // R1, R2: generate mode on random data
    sel = 1'b0;
    fill_rand(512);
    gen_and_compare("R1", 512, 3, 12);
    fill_rand(512);
    gen_and_compare("R1", 512, 3, 12);

    // R3: erased sector
    for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
    gen_and_compare("R3", 512, 3, 12);
    chk(cap_code[23:0] == 24'hFFFFFF, "R3", "erased code", cap_code[23:0], 24'hFFFFFF);
    run_sector(1'b1, 512, 3, 32'hFFFFFF, 1'b0);
    expect_res("R3", 2'd0, 9'd0, 8'd0);

    // R7, R6: clean check, code after and before the data
    fill_rand(512);
    good = model_code(512, 12);
    run_sector(1'b1, 512, 3, good, 1'b0);
    expect_res("R7", 2'd0, 9'd0, 8'd0);
    run_sector(1'b1, 512, 3, good, 1'b1);
    expect_res("R7", 2'd0, 9'd0, 8'd0);
    chk(!rdy && !crdy, "R5", "ready low after check sector", {rdy, crdy}, 0);

    // R4: back-to-back sectors must not share parity state
    fill_rand(512);
    good = model_code(512, 12);
    run_sector(1'b1, 512, 3, good, 1'b0);
    expect_res("R4", 2'd0, 9'd0, 8'd0);
    gen_and_compare("R4", 512, 3, 12);

    // R5: code port ready only until three bytes taken
    @(negedge clk); sos = 1'b1; mode = 1'b1;
    @(negedge clk); sos = 1'b0;
    chk(rdy && crdy, "R5", "ready after start", {rdy, crdy}, 2'b11);
    for (int j = 0; j < 3; j++) send(1'b1, good[j*8 +: 8]);
    chk(rdy && !crdy, "R5", "code port closed", {rdy, crdy}, 2'b10);
    for (int i = 0; i < 512; i++) send(1'b0, mem[i]);
    repeat (3) @(negedge clk);
    chk(r_st == 2'd0, "R4", "clean after partial-handshake sector", r_st, 0);

    // R8: single data-bit errors, corners plus random positions
    data_flip(512, 3, 12, 0);
    data_flip(512, 3, 12, 4095);
    data_flip(512, 3, 12, 7);
    for (int t = 0; t < 37; t++) data_flip(512, 3, 12, int'($urandom_range(4095)));

    // R10: every single code-bit error
    good = model_code(512, 12);
    for (int j = 0; j < 24; j++) begin
      run_sector(1'b1, 512, 3, good ^ (32'd1 << j), j[0]);
      expect_res("R10", 2'd2, 9'd0, 8'd0);
    end

    // R11: double data-bit errors
    for (int t = 0; t < 8; t++) begin
      a1 = int'($urandom_range(4095));
      a2 = (a1 + 1 + int'($urandom_range(4094))) % 4096;
      mem[a1/8][a1%8] = ~mem[a1/8][a1%8];
      mem[a2/8][a2%8] = ~mem[a2/8][a2%8];
      run_sector(1'b1, 512, 3, good, 1'b0);
      expect_res("R11", 2'd3, 9'd0, 8'd0);
      mem[a1/8][a1%8] = ~mem[a1/8][a1%8];
      mem[a2/8][a2%8] = ~mem[a2/8][a2%8];
    end

    // small sector: 6 bytes, 6-bit halves, 2 code bytes with padding ones
    sel = 1'b1;
    fill_rand(6);
    gen_and_compare("R1", 6, 2, 6);
    for (int a = 0; a < 48; a++) data_flip(6, 2, 6, a);
    good = model_code(6, 6);
    for (int j = 0; j < 12; j++) begin
      run_sector(1'b1, 6, 2, good ^ (32'd1 << j), 1'b0);
      expect_res("R10", 2'd2, 9'd0, 8'd0);
    end
    // R9: complementary halves pointing past the sector end
    for (int bi = 6; bi < 8; bi++)
      for (int bb = 0; bb < 8; bb += 5) begin
        hi = 32'(bi*8 + bb);
        lo = ~hi & 32'h3F;
        d  = (hi << 6) | lo;
        run_sector(1'b1, 6, 2, good ^ d, 1'b0);
        expect_res("R9", 2'd3, 9'd0, 8'd0);
      end

    summary_and_end();
  end

endmodule